// File: doc/BRIEF.md
# Region-Partitioned Way Selector for a Four-Way Level-One Data Cache

This block sits in front of the tag arrays of a four-way set-associative level-one data cache and decides which ways each lookup may touch. An address inside a programmable stack window is looked up only in the ways reserved for the stack. Any other address is looked up only in the remaining ways. All other ways keep their enables low, so the lookup spends energy on fewer arrays than a full parallel probe would. The block holds the tag, valid and dirty state as small register arrays. It reports hit or miss and the hit way. On a miss it picks the way to fill inside the requesting region, and it raises a write-back pulse when the line it displaces is dirty.

Software moves the split between the two regions at run time through a configuration port. A new split starts a sweep that walks every line slot of the cache, one per cycle. The sweep drops every line held in a way that changed sides, and it reports the dirty ones on the write-back outputs first. Lookups are held off until the sweep is over.

Top module: `rps_way_selector`

## Requirements
- R1: An address is in the stack region when stack_limit <= address <= stack_top, compared as unsigned numbers with both ends included. Every other address is in the non-stack region.
- R2: The stack owns ways 0 to N-1, where N is the stack way count, and the non-stack region owns ways N to 3. way_en is bit w for way w. For an accepted request it holds exactly the requester's region ways. With no accepted request it is 0.
- R3: en_count equals the number of bits set in way_en: N for a stack access, 4-N for a non-stack access, and 0 when no request is accepted.
- R4: A request hits only when a valid line with the same tag and set sits in one of its own region's ways. hit_way then names that way. Set = address bits [6:4] and tag = address bits [31:7] with the default sizes.
- R5: On a miss, victim_way is the lowest-numbered invalid way of the region. If every way of the region is valid, it is the way of the region used least recently. The tag is installed there, and the line is dirty when the request writes. A write hit marks the line dirty.
- R6: A miss whose victim is valid and dirty raises wb_valid in the same cycle, with the victim's set, way and tag. A clean or invalid victim raises no write-back.
- R7: A configuration write with a stack way count of 0, or one made while busy, is ignored entirely. An accepted write loads both bounds at once. If the count changes, busy rises at the next cycle and stays high for exactly SETS*4 cycles. While busy, way_en is 0 and requests change no state.
- R8: During the sweep, every valid line in a way whose owner changed is invalidated. Each such line that is dirty first gives one wb_valid pulse with its set, way and tag. Lines in ways that kept their owner survive.
- R9: A request made in the same cycle as an accepted configuration write is served under the partition and bounds in force before that write.
- R10: After reset, no line is valid, busy is 0, the stack way count is STACK_WAYS_RST (2), both bounds equal their reset parameters (0), and LRU order ranks way 0 newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | Request is a store |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stack_ways | input | 2 | New stack way count, 1 to 3 (0 rejects the write) |
| cfg_stack_limit | input | ADDR_W | New lower bound of the stack window |
| cfg_stack_top | input | ADDR_W | New upper bound of the stack window |
| busy | output | 1 | Repartition sweep running; requests are not accepted |
| way_en | output | 4 | Per-way array enables for this lookup |
| en_count | output | 3 | Number of ways enabled for this lookup |
| hit | output | 1 | Accepted request hit |
| hit_way | output | 2 | Way that hit |
| miss | output | 1 | Accepted request missed; a fill takes place |
| victim_way | output | 2 | Way chosen for the fill on a miss |
| wb_valid | output | 1 | A dirty line leaves the cache this cycle |
| wb_set | output | IDX_W | Set of the departing line |
| wb_way | output | 2 | Way of the departing line |
| wb_tag | output | TAG_W | Tag of the departing line |

## Verification
A lookup and a repartition request can arrive in the same cycle. The bench provokes this by asserting a stack request and a configuration write that shrinks the stack share on one clock edge. It judges the outcome in three ways. That cycle's way_en and en_count must still show the old three-way stack share. The fill must land in way 0. After the sweep, the line must still hit in way 0 under the new single-way share. The sweep itself is judged by its length, by the write-backs of dirty lines in moved ways, by enables held low for a request left waiting across it, and by a miss later on for that blocked address.

// File: rtl/rps_pkg.sv
package rps_pkg;
   localparam int NWAYS = 4;
   localparam int WIDX  = 2;

   typedef logic [NWAYS-1:0] way_mask_t;
   typedef logic [WIDX-1:0]  way_idx_t;

   // Ways owned by the stack: the lowest n ways.
   function automatic way_mask_t low_ways(input logic [WIDX-1:0] n);
      case (n)
         2'd1:    return 4'b0001;
         2'd2:    return 4'b0011;
         2'd3:    return 4'b0111;
         default: return 4'b0000;
      endcase
   endfunction

   // Lowest set bit as an index (0 when empty).
   function automatic way_idx_t first_way(input way_mask_t m);
      way_idx_t r = '0;
      for (int w = NWAYS - 1; w >= 0; w--) begin
         if (m[w]) r = way_idx_t'(w);
      end
      return r;
   endfunction
endpackage

// File: rtl/rps_region_decode.sv
module rps_region_decode
   import rps_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lim,
   input  logic [ADDR_W-1:0] top,
   input  logic [WIDX-1:0]   stack_n,
   input  logic              accept,
   output logic              in_stack,
   output way_mask_t         region_mask,
   output way_mask_t         way_en,
   output logic [2:0]        en_count
);
   way_mask_t smask;

   always_comb begin
      smask       = low_ways(stack_n);
      in_stack    = (addr >= lim) && (addr <= top);
      region_mask = in_stack ? smask : ~smask;
      way_en      = accept ? region_mask : '0;
      if (!accept)       en_count = 3'd0;
      else if (in_stack) en_count = {1'b0, stack_n};
      else               en_count = 3'd4 - {1'b0, stack_n};
   end
endmodule

// File: rtl/rps_tag_store.sv
module rps_tag_store
   import rps_pkg::*;
#(
   parameter int SETS  = 8,
   parameter int IDX_W = 3,
   parameter int TAG_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_set,
   input  logic [TAG_W-1:0] look_tag,
   input  way_mask_t        look_mask,
   input  way_idx_t         rd_way,
   output way_mask_t        hit_vec,
   output way_mask_t        vld_row,
   output way_mask_t        drt_row,
   output logic [TAG_W-1:0] way_tag,
   input  logic             fill_en,
   input  way_idx_t         fill_way,
   input  logic             fill_dirty,
   input  logic             mark_en,
   input  way_idx_t         mark_way,
   input  logic             clr_en,
   input  way_idx_t         clr_way
);
   logic [TAG_W-1:0] tags [SETS][NWAYS];
   way_mask_t        vld  [SETS];
   way_mask_t        drt  [SETS];

   for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
      assign hit_vec[w] = look_mask[w] && vld[rd_set][w] && (tags[rd_set][w] == look_tag);
   end

   assign vld_row = vld[rd_set];
   assign drt_row = drt[rd_set];
   assign way_tag = tags[rd_set][rd_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld[s] <= '0;
            drt[s] <= '0;
         end
      end else begin
         if (fill_en) begin
            vld[rd_set][fill_way] <= 1'b1;
            drt[rd_set][fill_way] <= fill_dirty;
         end
         if (mark_en) drt[rd_set][mark_way] <= 1'b1;
         if (clr_en) begin
            vld[rd_set][clr_way] <= 1'b0;
            drt[rd_set][clr_way] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tags[rd_set][fill_way] <= look_tag;
   end

   // A region never holds the same line twice.
   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R4
   // A dirty line is always a valid line.
   AST_DIRTY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (drt_row & ~vld_row) == '0); // R5
endmodule

// File: rtl/rps_lru.sv
module rps_lru
   import rps_pkg::*;
#(
   parameter int SETS  = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_idx,
   input  way_mask_t        mask,
   input  logic             touch_en,
   input  way_idx_t         touch_way,
   output way_idx_t         lru_way
);
   // Age rank per way: 0 newest, 3 oldest; each row is a permutation.
   way_idx_t age [SETS][NWAYS];
   logic [NWAYS-1:0] rank_seen;

   always_comb begin
      way_idx_t best_age;
      logic     found;
      lru_way  = '0;
      best_age = '0;
      found    = 1'b0;
      for (int w = 0; w < NWAYS; w++) begin
         if (mask[w] && (!found || age[set_idx][w] > best_age)) begin
            found    = 1'b1;
            best_age = age[set_idx][w];
            lru_way  = way_idx_t'(w);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < NWAYS; w++)
               age[s][w] <= way_idx_t'(w);
      end else if (touch_en) begin
         for (int w = 0; w < NWAYS; w++) begin
            if (way_idx_t'(w) == touch_way)
               age[set_idx][w] <= '0;
            else if (age[set_idx][w] < age[set_idx][touch_way])
               age[set_idx][w] <= age[set_idx][w] + 2'd1;
         end
      end
   end

   always_comb begin
      rank_seen = '0;
      for (int w = 0; w < NWAYS; w++) rank_seen[age[set_idx][w]] = 1'b1;
   end

   AST_LRU_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
      rank_seen == '1); // R5
   AST_LRU_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (mask != '0) |-> mask[lru_way]); // R5
endmodule

// File: rtl/rps_repart.sv
module rps_repart
   import rps_pkg::*;
#(
   parameter int                ADDR_W         = 32,
   parameter int                SETS           = 8,
   parameter int                IDX_W          = 3,
   parameter int                STACK_WAYS_RST = 2,
   parameter logic [ADDR_W-1:0] LIMIT_RST      = '0,
   parameter logic [ADDR_W-1:0] TOP_RST        = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WIDX-1:0]   cfg_n,
   input  logic [ADDR_W-1:0] cfg_lim,
   input  logic [ADDR_W-1:0] cfg_top,
   output logic [WIDX-1:0]   stack_n,
   output logic [ADDR_W-1:0] lim,
   output logic [ADDR_W-1:0] top,
   output logic              busy,
   output logic [IDX_W-1:0]  sw_set,
   output way_idx_t          sw_way,
   output logic              sw_act
);
   localparam int CNT_W = IDX_W + WIDX;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETS * NWAYS - 1);

   logic [CNT_W-1:0] cnt;
   way_mask_t        moved;
   logic             cfg_ok;

   assign cfg_ok = cfg_we && (cfg_n != '0) && !busy;
   assign sw_set = cnt[CNT_W-1:WIDX];
   assign sw_way = cnt[WIDX-1:0];
   assign sw_act = busy && moved[sw_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stack_n <= WIDX'(STACK_WAYS_RST);
         lim     <= LIMIT_RST;
         top     <= TOP_RST;
         busy    <= 1'b0;
         cnt     <= '0;
         moved   <= '0;
      end else if (busy) begin
         if (cnt == LAST) busy <= 1'b0;
         cnt <= cnt + 1'b1;
      end else if (cfg_ok) begin
         stack_n <= cfg_n;
         lim     <= cfg_lim;
         top     <= cfg_top;
         if (cfg_n != stack_n) begin
            busy  <= 1'b1;
            cnt   <= '0;
            moved <= low_ways(stack_n) ^ low_ways(cfg_n);
         end
      end
   end

   AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(cnt) == LAST); // R7
   AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      stack_n != '0); // R7
   AST_CFG_HELD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(stack_n) && $stable(lim) && $stable(top)); // R7
endmodule

// File: rtl/rps_way_selector.sv
module rps_way_selector
   import rps_pkg::*;
#(
   parameter int                ADDR_W         = 32,
   parameter int                SETS           = 8,
   parameter int                LINE_BYTES     = 16,
   parameter int                STACK_WAYS_RST = 2,
   parameter logic [ADDR_W-1:0] LIMIT_RST      = '0,
   parameter logic [ADDR_W-1:0] TOP_RST        = '0,
   localparam int               OFF_W          = $clog2(LINE_BYTES),
   localparam int               IDX_W          = $clog2(SETS),
   localparam int               TAG_W          = ADDR_W - OFF_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_stack_ways,
   input  logic [ADDR_W-1:0] cfg_stack_limit,
   input  logic [ADDR_W-1:0] cfg_stack_top,
   output logic              busy,
   output logic [3:0]        way_en,
   output logic [2:0]        en_count,
   output logic              hit,
   output logic [1:0]        hit_way,
   output logic              miss,
   output logic [1:0]        victim_way,
   output logic              wb_valid,
   output logic [IDX_W-1:0]  wb_set,
   output logic [1:0]        wb_way,
   output logic [TAG_W-1:0]  wb_tag
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two, at least 2");
   end
   if (STACK_WAYS_RST < 1 || STACK_WAYS_RST > NWAYS - 1) begin : g_bad_split
      $error("STACK_WAYS_RST must leave at least one way per region");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the cache geometry");
   end

   logic [WIDX-1:0]   stack_n;
   logic [ADDR_W-1:0] lim, top;
   logic [IDX_W-1:0]  sw_set;
   way_idx_t          sw_way;
   logic              sw_act;
   logic              accept, in_stack, any_hit, do_fill;
   way_mask_t         region_mask, hit_vec, vld_row, drt_row, free_ways;
   way_idx_t          lru_way, pick_way, rd_way;
   logic [IDX_W-1:0]  req_set, rd_set;
   logic [TAG_W-1:0]  req_tag, way_tag;

   assign req_set = req_addr[OFF_W +: IDX_W];
   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
   assign accept  = req_valid && !busy;

   rps_repart #(
      .ADDR_W(ADDR_W), .SETS(SETS), .IDX_W(IDX_W),
      .STACK_WAYS_RST(STACK_WAYS_RST), .LIMIT_RST(LIMIT_RST), .TOP_RST(TOP_RST)
   ) u_repart (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_n(cfg_stack_ways),
      .cfg_lim(cfg_stack_limit), .cfg_top(cfg_stack_top),
      .stack_n(stack_n), .lim(lim), .top(top), .busy(busy),
      .sw_set(sw_set), .sw_way(sw_way), .sw_act(sw_act)
   );

   rps_region_decode #(.ADDR_W(ADDR_W)) u_region (
      .addr(req_addr), .lim(lim), .top(top), .stack_n(stack_n),
      .accept(accept), .in_stack(in_stack), .region_mask(region_mask),
      .way_en(way_en), .en_count(en_count)
   );

   // One read port: the sweep owns it while busy, the request otherwise.
   assign rd_set    = busy ? sw_set : req_set;
   assign any_hit   = |hit_vec;
   assign free_ways = region_mask & ~vld_row;
   assign pick_way  = (free_ways != '0) ? first_way(free_ways) : lru_way;
   assign rd_way    = busy ? sw_way : pick_way;
   assign do_fill   = accept && !any_hit;

   rps_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_set(rd_set), .look_tag(req_tag), .look_mask(region_mask), .rd_way(rd_way),
      .hit_vec(hit_vec), .vld_row(vld_row), .drt_row(drt_row), .way_tag(way_tag),
      .fill_en(do_fill), .fill_way(pick_way), .fill_dirty(req_write),
      .mark_en(accept && any_hit && req_write), .mark_way(first_way(hit_vec)),
      .clr_en(sw_act), .clr_way(sw_way)
   );

   rps_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .set_idx(rd_set), .mask(region_mask),
      .touch_en(accept), .touch_way(any_hit ? first_way(hit_vec) : pick_way),
      .lru_way(lru_way)
   );

   assign hit        = accept && any_hit;
   assign hit_way    = first_way(hit_vec);
   assign miss       = do_fill;
   assign victim_way = pick_way;
   assign wb_valid   = busy ? (sw_act && vld_row[sw_way] && drt_row[sw_way])
                            : (do_fill && vld_row[pick_way] && drt_row[pick_way]);
   assign wb_set     = rd_set;
   assign wb_way     = rd_way;
   assign wb_tag     = way_tag;

   AST_EN_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      32'(en_count) == $countones(way_en)); // R3
   AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (way_en == '0) && !hit && !miss); // R7
   AST_HIT_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> way_en[hit_way]); // R4
   AST_VICTIM_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> way_en[victim_way]); // R5
   AST_REGIONS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (in_stack ? !way_en[NWAYS-1] : !way_en[0])); // R2
endmodule

// File: tb/rps_way_selector_test.sv
`timescale 1ns/1ps
module rps_way_selector_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_stack_ways = '0;
   logic [31:0] cfg_stack_limit = '0, cfg_stack_top = '0;
   logic        busy, hit, miss, wb_valid;
   logic [3:0]  way_en;
   logic [2:0]  en_count;
   logic [1:0]  hit_way, victim_way, wb_way;
   logic [2:0]  wb_set;
   logic [24:0] wb_tag;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   // sampled results of the last request
   logic [3:0]  s_en;
   logic [2:0]  s_cnt;
   logic        s_hit, s_miss, s_wb;
   logic [1:0]  s_hway, s_vway, s_wbway;
   logic [2:0]  s_wbset;
   logic [24:0] s_wbtag;

   localparam logic [31:0] LIM = 32'h8000_0000;
   localparam logic [31:0] TOP = 32'h8000_0FFF;

   rps_way_selector uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .cfg_we(cfg_we), .cfg_stack_ways(cfg_stack_ways),
      .cfg_stack_limit(cfg_stack_limit), .cfg_stack_top(cfg_stack_top),
      .busy(busy), .way_en(way_en), .en_count(en_count),
      .hit(hit), .hit_way(hit_way), .miss(miss), .victim_way(victim_way),
      .wb_valid(wb_valid), .wb_set(wb_set), .wb_way(wb_way), .wb_tag(wb_tag)
   );

   always #10 clk = ~clk;

   function automatic logic [24:0] tag_of(input logic [31:0] a);
      return a[31:7];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic eq(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
      check(act === exp, req, what, act, exp);
   endtask

   task automatic do_req(input logic [31:0] a, input logic w);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w;
      #5;
      s_en = way_en; s_cnt = en_count; s_hit = hit; s_miss = miss;
      s_hway = hit_way; s_vway = victim_way; s_wb = wb_valid;
      s_wbway = wb_way; s_wbset = wb_set; s_wbtag = wb_tag;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic do_cfg(input logic [1:0] n, input logic [31:0] l, input logic [31:0] t);
      @(negedge clk);
      cfg_we = 1'b1; cfg_stack_ways = n; cfg_stack_limit = l; cfg_stack_top = t;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   // Watch a sweep; optionally keep a blocked request asserted during it.
   task automatic watch_sweep(input bit hold, input logic [31:0] a,
                              output int nbusy, output int nwb, output int nen,
                              output logic [2:0] wset, output logic [1:0] wway,
                              output logic [24:0] wtag);
      nbusy = 0; nwb = 0; nen = 0; wset = '0; wway = '0; wtag = '0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (hold) begin req_valid = 1'b1; req_addr = a; req_write = 1'b1; end
         #5;
         if (!busy) begin
            req_valid = 1'b0; req_write = 1'b0;
            break;
         end
         nbusy++;
         if (way_en != '0 || hit || miss) nen++;
         if (wb_valid) begin nwb++; wset = wb_set; wway = wb_way; wtag = wb_tag; end
      end
   endtask

   task automatic t_reset;
      #5;
      eq("R10", "busy after reset", busy, 0);
      eq("R2", "way_en idle", way_en, 0);
      eq("R3", "en_count idle", en_count, 0);
      do_req(32'h0000_0000, 1'b0);   // default bounds 0..0, two stack ways
      eq("R10", "reset window way_en", s_en, 4'b0011);
      eq("R10", "cold lookup misses", s_miss, 1);
      eq("R10", "cold victim way", s_vway, 0);
      do_cfg(2'd2, LIM, TOP);
      @(negedge clk); #5;
      eq("R7", "same count no sweep", busy, 0);
   endtask

   task automatic t_region;
      do_req(LIM - 32'd16, 1'b0);
      eq("R1", "below limit non-stack", s_en, 4'b1100);
      eq("R3", "non-stack count", s_cnt, 2);
      do_req(LIM, 1'b0);
      eq("R1", "limit inclusive", s_en, 4'b0011);
      eq("R3", "stack count", s_cnt, 2);
      do_req(TOP, 1'b0);
      eq("R1", "top inclusive", s_en, 4'b0011);
      do_req(TOP + 32'd1, 1'b0);
      eq("R2", "above top non-stack", s_en, 4'b1100);
   endtask

   task automatic t_fill_lru;
      logic [31:0] a, b, c;
      a = 32'h1000_0030; b = 32'h1000_00B0; c = 32'h1000_0130; // all set 3
      do_req(a, 1'b1);
      eq("R5", "first free way", s_vway, 2);
      eq("R5", "A miss", s_miss, 1);
      do_req(a, 1'b0);
      eq("R4", "A hits", s_hit, 1);
      eq("R4", "A hit way", s_hway, 2);
      do_req(b, 1'b0);
      eq("R5", "next free way", s_vway, 3);
      do_req(c, 1'b0);
      eq("R5", "LRU victim", s_vway, 2);
      eq("R6", "dirty evict wb", s_wb, 1);
      eq("R6", "wb tag", s_wbtag, tag_of(a));
      eq("R6", "wb set", s_wbset, 3);
      eq("R6", "wb way", s_wbway, 2);
      do_req(c, 1'b0);
      eq("R4", "C hits way 2", {s_hit, s_hway}, {1'b1, 2'd2});
      do_req(a, 1'b0);
      eq("R5", "LRU victim after reuse", s_vway, 3);
      eq("R6", "clean evict no wb", s_wb, 0);
   endtask

   task automatic t_cfg_ignore;
      do_cfg(2'd0, 32'h0, 32'hFFFF_FFFF);
      @(negedge clk); #5;
      eq("R7", "zero count no busy", busy, 0);
      do_req(LIM, 1'b0);
      eq("R7", "zero count ignored (bounds)", s_en, 4'b0011);
      eq("R7", "zero count ignored (split)", s_cnt, 2);
   endtask

   task automatic t_repartition;
      logic [31:0] s, n2, n3, z;
      int nb, nw, ne;
      logic [2:0] ws; logic [1:0] ww; logic [24:0] wt;
      s = 32'h8000_0020; n2 = 32'h2000_0020; n3 = 32'h3000_0020; z = 32'h5000_0020;
      do_req(s, 1'b1);
      eq("R5", "stack fill way", s_vway, 0);
      do_req(n2, 1'b1);
      eq("R5", "N2 fill way", s_vway, 2);
      do_req(n3, 1'b0);
      eq("R5", "N3 fill way", s_vway, 3);
      do_cfg(2'd3, LIM, TOP);
      watch_sweep(1'b1, z, nb, nw, ne, ws, ww, wt);
      eq("R7", "sweep length", nb, 32);
      eq("R7", "no lookup while busy", ne, 0);
      eq("R8", "one dirty write-back", nw, 1);
      eq("R8", "sweep wb tag", wt, tag_of(n2));
      eq("R8", "sweep wb set/way", {ws, ww}, {3'd2, 2'd2});
      do_req(n3, 1'b0);
      eq("R8", "unmoved non-stack kept", {s_hit, s_hway}, {1'b1, 2'd3});
      eq("R2", "one non-stack way", s_en, 4'b1000);
      eq("R3", "one way counted", s_cnt, 1);
      do_req(s, 1'b0);
      eq("R8", "stack line kept", {s_hit, s_hway}, {1'b1, 2'd0});
      eq("R3", "three stack ways", s_cnt, 3);
      do_req(z, 1'b0);
      eq("R7", "blocked request left no line", s_miss, 1);
      do_req(n2, 1'b0);
      eq("R8", "moved line dropped", s_miss, 1);
   endtask

   task automatic t_same_cycle;
      logic [31:0] r;
      int nb, nw, ne;
      logic [2:0] ws; logic [1:0] ww; logic [24:0] wt;
      r = 32'h8000_0040; // set 4, stack
      @(negedge clk);
      req_valid = 1'b1; req_addr = r; req_write = 1'b0;
      cfg_we = 1'b1; cfg_stack_ways = 2'd1; cfg_stack_limit = LIM; cfg_stack_top = TOP;
      #5;
      eq("R9", "old split in shared cycle", way_en, 4'b0111);
      eq("R9", "old count in shared cycle", en_count, 3);
      eq("R9", "fill way in shared cycle", {miss, victim_way}, {1'b1, 2'd0});
      @(posedge clk); #1;
      req_valid = 1'b0; cfg_we = 1'b0;
      watch_sweep(1'b0, 32'h0, nb, nw, ne, ws, ww, wt);
      eq("R7", "second sweep length", nb, 32);
      eq("R8", "clean moved ways no wb", nw, 0);
      do_req(r, 1'b0);
      eq("R9", "line survives under new split", {s_hit, s_hway}, {1'b1, 2'd0});
      eq("R2", "single stack way", s_en, 4'b0001);
      do_req(32'h1000_0000, 1'b0);
      eq("R2", "three non-stack ways", s_en, 4'b1110);
      eq("R3", "three counted", s_cnt, 3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_region();
      t_fill_lru();
      t_cfg_ignore();
      t_repartition();
      t_same_cycle();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule